// File: doc/BRIEF.md
# Register and RAM Access Sequencer

This block sits between a byte-level serial front end and a bank of thirty 8-bit registers with a 512-byte scratch RAM behind them. A transaction opens with a start pulse. The first byte sets a 5-bit register pointer. Each later byte is either a write or a read at the pointer, and after every data byte the pointer moves on by its own rule. Two addresses are not storage. One pushes a byte into the RAM and the other pulls a byte out of it. The RAM location comes from a 9-bit index that is kept in two registers of this block and advances after each RAM access.

Registers 00h to 19h belong to other function blocks. This block forwards accesses to them through a simple strobe port and returns their read value one cycle later. While a transaction is open, the block holds a freeze request so that the timekeeping counters cannot carry mid-access. It also holds back the one-second tick during that time and delivers one delayed tick once the freeze is released.

Top module: `reg_access_ctrl`

## Requirements
- R1: After reset, `freeze`, `tick_out`, `rdata_valid` and `rdata` are 0, and the 9-bit RAM index is 0, so reads of 1Ah and 1Bh return 00h.
- R2: The first `byte_valid` after `start` loads the pointer from `wdata[4:0]`, whatever `rw` is. It starts no read (no `rdata_valid`) and no register strobe.
- R3: After each data byte at pointer 00h–1Ah the pointer increases by one. From 1Bh it wraps to 00h, and from the unused addresses 1Eh and 1Fh it also goes to 00h. The current pointer is always visible on `reg_addr`.
- R4: At pointer 1Ch or 1Dh the pointer stays put after a data byte, so consecutive bytes stream through the same command address.
- R5: The RAM index is split across two addresses. Bit 8 is bit 0 of address 1Ah and bits 7:0 are address 1Bh. Both can be written and read back, and bits 7:1 of 1Ah read as 0.
- R6: A write byte at 1Ch stores `wdata` in RAM at the RAM index, then the index increases by one, wrapping from 511 to 0.
- R7: A read byte at 1Dh returns the RAM byte at the RAM index, then the index increases by one, wrapping from 511 to 0.
- R8: Reads of 1Ch, 1Eh and 1Fh return 00h. Writes to 1Dh, 1Eh and 1Fh change neither the RAM nor the RAM index.
- R9: A data byte at 00h–19h raises `reg_we` (write) or `reg_re` (read) in that same cycle, with `reg_addr` equal to the pointer. No strobe is raised for 1Ah–1Fh.
- R10: A read data byte in the data phase gives `rdata_valid` high for exactly the next cycle, with `rdata` carrying the value. `rdata` holds its value otherwise.
- R11: `freeze` is high from the cycle after `start` up to and including the edge that samples `end_txn`, and low the cycle after that.
- R12: While not frozen, a `tick_in` pulse appears on `tick_out` one cycle later. Ticks arriving while frozen are merged into one pending tick. That tick appears on `tick_out` in the second cycle after the edge that samples `end_txn`.
- R13: A `byte_valid` outside a transaction has no effect: no strobe, no `rdata_valid`, and no change to the pointer or the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a transaction; the next byte is the address |
| end_txn | input | 1 | Closes the transaction |
| byte_valid | input | 1 | One byte offered this cycle |
| rw | input | 1 | 1 = read, 0 = write for a data byte |
| wdata | input | 8 | Address byte or write data |
| rdata | output | 8 | Read data, registered |
| rdata_valid | output | 1 | `rdata` updated by the previous read byte |
| reg_addr | output | 5 | Current register pointer |
| reg_we | output | 1 | Write strobe toward registers 00h–19h |
| reg_re | output | 1 | Read strobe toward registers 00h–19h |
| reg_wdata | output | 8 | Write data toward the registers |
| reg_rdata | input | 8 | Combinational read value of register `reg_addr` |
| tick_in | input | 1 | One-second tick from the prescaler |
| tick_out | output | 1 | Tick forwarded to the time counters |
| freeze | output | 1 | Freeze request to the time counters |

## Verification
A pointer that steps wrongly shows up on `reg_addr` on the very next byte. A bad RAM index appears on the next 1Dh read or on a readback of 1Ah/1Bh, and the bench reads these after every pointer-disturbing case. A freeze or tick-hold fault is visible within one or two cycles of `start` or `end_txn`. Every byte is compared against a bench model of the pointer, the RAM index and the RAM, so a corrupted stored byte appears on the first read of that location.

// File: rtl/rac_pkg.sv
// Shared constants and types for the register/RAM access sequencer.
// Assumes a 5-bit register address space with the special addresses below.
package rac_pkg;
    localparam int REG_AW = 5;
    localparam logic [REG_AW-1:0] ADR_LAST_EXT = 5'h19;
    localparam logic [REG_AW-1:0] ADR_IDX_HI   = 5'h1A;
    localparam logic [REG_AW-1:0] ADR_IDX_LO   = 5'h1B;
    localparam logic [REG_AW-1:0] ADR_RAM_PUSH = 5'h1C;
    localparam logic [REG_AW-1:0] ADR_RAM_PULL = 5'h1D;

    typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} rac_phase_e;
endpackage

// File: rtl/rac_pointer.sv
// Transaction phase tracker and auto-stepping register pointer.
// Assumes start has priority over end_txn, and end_txn over a byte.
module rac_pointer
    import rac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              end_txn,
    input  logic              byte_valid,
    input  logic [REG_AW-1:0] addr_in,
    output logic [REG_AW-1:0] ptr,
    output logic              data_stb
);
    rac_phase_e        phase_q;
    logic [REG_AW-1:0] ptr_q;
    logic [REG_AW-1:0] ptr_step;

    // Qualified data byte: inside a transaction, past the address byte.
    assign data_stb = byte_valid && (phase_q == PH_DATA) && !start && !end_txn;

    // Next pointer value after a data byte.
    always_comb begin
        if (ptr_q == ADR_RAM_PUSH || ptr_q == ADR_RAM_PULL)
            ptr_step = ptr_q;
        else if (ptr_q >= ADR_IDX_LO)
            ptr_step = '0;
        else
            ptr_step = ptr_q + 1'b1;
    end

    // Phase and pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            ptr_q   <= '0;
        end else if (start) begin
            phase_q <= PH_ADDR;
        end else if (end_txn) begin
            phase_q <= PH_IDLE;
        end else if (byte_valid && phase_q == PH_ADDR) begin
            ptr_q   <= addr_in;
            phase_q <= PH_DATA;
        end else if (data_stb) begin
            ptr_q   <= ptr_step;
        end
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/rac_ram_port.sv
// Scratch RAM with a self-advancing 9-bit index loaded in two halves.
// Assumes the low half of the index is no wider than a data byte.
module rac_ram_port #(
    parameter int DATA_W = 8,
    parameter int RAM_AW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wdata,
    input  logic              set_hi,
    input  logic              set_lo,
    input  logic              push,
    input  logic              pull,
    output logic [RAM_AW-1:0] idx,
    output logic [DATA_W-1:0] ram_rdata
);
    localparam int DEPTH = 1 << RAM_AW;
    localparam int LO_W  = RAM_AW - 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [RAM_AW-1:0] idx_q;

    // Index register: loaded by halves, advanced after each RAM access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (set_hi)
            idx_q[RAM_AW-1] <= wdata[0];
        else if (set_lo)
            idx_q[LO_W-1:0] <= wdata[LO_W-1:0];
        else if (push || pull)
            idx_q <= idx_q + 1'b1;
    end

    // Storage write at the current index.
    always_ff @(posedge clk) begin
        if (push)
            mem[idx_q] <= wdata;
    end

    assign ram_rdata = mem[idx_q];
    assign idx       = idx_q;
endmodule

// File: rtl/rac_freeze.sv
// Freeze request for the time counters plus one-deep hold of the second tick.
// Assumes tick_in is a single-cycle pulse.
module rac_freeze (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic end_txn,
    input  logic tick_in,
    output logic freeze,
    output logic tick_out
);
    logic freeze_q, pend_q, tick_q;

    // Freeze spans the open transaction.
    always_ff @(posedge clk) begin
        if (!rst_n)       freeze_q <= 1'b0;
        else if (start)   freeze_q <= 1'b1;
        else if (end_txn) freeze_q <= 1'b0;
    end

    // Pending tick captured while frozen, cleared once delivered.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pend_q <= 1'b0;
        else if (freeze_q && tick_in) pend_q <= 1'b1;
        else if (!freeze_q)           pend_q <= 1'b0;
    end

    // Forwarded tick: live tick or the held one, only when unfrozen.
    always_ff @(posedge clk) begin
        if (!rst_n) tick_q <= 1'b0;
        else        tick_q <= !freeze_q && (tick_in || pend_q);
    end

    assign freeze   = freeze_q;
    assign tick_out = tick_q;
endmodule

// File: rtl/reg_access_ctrl.sv
// Top of the register/RAM access sequencer: pointer, RAM command ports,
// forwarded register strobes, registered read data and freeze handshake.
// Assumes reg_rdata is a combinational function of reg_addr.
module reg_access_ctrl
    import rac_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int RAM_AW = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              end_txn,
    input  logic              byte_valid,
    input  logic              rw,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_valid,
    output logic [REG_AW-1:0] reg_addr,
    output logic              reg_we,
    output logic              reg_re,
    output logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              tick_in,
    output logic              tick_out,
    output logic              freeze
);
    localparam int LO_W = RAM_AW - 1;

    logic [REG_AW-1:0] ptr;
    logic              data_stb, rd_stb, wr_stb, is_ext;
    logic [RAM_AW-1:0] idx;
    logic [DATA_W-1:0] ram_rdata, rd_mux, rdata_q;
    logic              rvalid_q;

    rac_pointer u_ptr (
        .clk(clk), .rst_n(rst_n), .start(start), .end_txn(end_txn),
        .byte_valid(byte_valid), .addr_in(wdata[REG_AW-1:0]),
        .ptr(ptr), .data_stb(data_stb)
    );

    assign rd_stb = data_stb && rw;
    assign wr_stb = data_stb && !rw;
    assign is_ext = (ptr <= ADR_LAST_EXT);

    rac_ram_port #(.DATA_W(DATA_W), .RAM_AW(RAM_AW)) u_ram (
        .clk(clk), .rst_n(rst_n), .wdata(wdata),
        .set_hi(wr_stb && ptr == ADR_IDX_HI),
        .set_lo(wr_stb && ptr == ADR_IDX_LO),
        .push(wr_stb && ptr == ADR_RAM_PUSH),
        .pull(rd_stb && ptr == ADR_RAM_PULL),
        .idx(idx), .ram_rdata(ram_rdata)
    );

    rac_freeze u_frz (
        .clk(clk), .rst_n(rst_n), .start(start), .end_txn(end_txn),
        .tick_in(tick_in), .freeze(freeze), .tick_out(tick_out)
    );

    // Read source selection by pointer.
    always_comb begin
        if (is_ext)                    rd_mux = reg_rdata;
        else if (ptr == ADR_IDX_HI)    rd_mux = DATA_W'(idx[RAM_AW-1]);
        else if (ptr == ADR_IDX_LO)    rd_mux = DATA_W'(idx[LO_W-1:0]);
        else if (ptr == ADR_RAM_PULL)  rd_mux = ram_rdata;
        else                           rd_mux = '0;
    end

    // Registered read data and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd_stb;
            if (rd_stb) rdata_q <= rd_mux;
        end
    end

    assign rdata       = rdata_q;
    assign rdata_valid = rvalid_q;
    assign reg_addr    = ptr;
    assign reg_we      = wr_stb && is_ext;
    assign reg_re      = rd_stb && is_ext;
    assign reg_wdata   = wdata;
endmodule

// File: rtl/rac_checker.sv
// Temporal checks for reg_access_ctrl, attached by bind.
module rac_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       end_txn,
    input logic       rw,
    input logic       data_stb,
    input logic       rdata_valid,
    input logic [4:0] reg_addr,
    input logic       reg_we,
    input logic       reg_re,
    input logic       freeze,
    input logic       tick_out
);
    a_r3_wrap_after_1b: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb && reg_addr == 5'h1B |=> reg_addr == 5'h00);

    a_r4_hold_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb && (reg_addr == 5'h1C || reg_addr == 5'h1D) |=> $stable(reg_addr));

    a_r9_we_range: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> reg_addr <= 5'h19);

    a_r9_re_range: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> reg_addr <= 5'h19);

    a_r10_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb && rw |=> rdata_valid);

    a_r10_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_stb && rw) |=> !rdata_valid);

    a_r11_freeze_rise: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> freeze);

    a_r11_freeze_fall: assert property (@(posedge clk) disable iff (!rst_n)
        end_txn && !start |=> !freeze);

    a_r12_no_tick_when_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> !$past(freeze));
endmodule

bind reg_access_ctrl rac_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .end_txn(end_txn), .rw(rw),
    .data_stb(data_stb), .rdata_valid(rdata_valid), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_re(reg_re), .freeze(freeze), .tick_out(tick_out)
);

// File: tb/reg_access_ctrl_bench.sv
// Self-checking bench: directed corner cases plus seeded random transactions
// compared against a bench model of pointer, RAM index and RAM.
module reg_access_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       start = 1'b0, end_txn = 1'b0, byte_valid = 1'b0, rw = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, reg_wdata, reg_rdata;
    logic       rdata_valid, reg_we, reg_re, tick_out, freeze;
    logic [4:0] reg_addr;
    logic       tick_in = 1'b0;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    // Bench model state.
    logic [7:0] ram_m [512];
    logic [8:0] idx_m = '0;
    logic [4:0] ptr_m = '0;
    int         phase_m = 0; // 0 idle, 1 address, 2 data

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] ext_val(input logic [4:0] a);
        return (8'(a) * 8'd37) ^ 8'h5A;
    endfunction

    function automatic logic [4:0] ptr_next(input logic [4:0] p);
        if (p == 5'h1C || p == 5'h1D) return p;
        if (p >= 5'h1B) return 5'h00;
        return p + 5'd1;
    endfunction

    assign reg_rdata = ext_val(reg_addr);

    reg_access_ctrl u_reg_access_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .end_txn(end_txn),
        .byte_valid(byte_valid), .rw(rw), .wdata(wdata), .rdata(rdata),
        .rdata_valid(rdata_valid), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_re(reg_re), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tick_in(tick_in), .tick_out(tick_out), .freeze(freeze)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic begin_txn();
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        phase_m = 1;
        chk("R11 freeze after start", 16'(freeze), 16'h1);
    endtask

    task automatic finish_txn();
        end_txn = 1'b1;
        @(posedge clk); #1;
        end_txn = 1'b0;
        phase_m = 0;
        chk("R11 freeze after end", 16'(freeze), 16'h0);
    endtask

    // One byte; checks strobes before the edge and read data after it.
    task automatic byte_op(input bit r, input logic [7:0] d);
        logic [7:0] exp;
        bit is_rd;
        exp = '0;
        is_rd = 1'b0;
        byte_valid = 1'b1; rw = r; wdata = d;
        #1;
        if (phase_m == 2) begin
            chk("R3 pointer on reg_addr", 16'(reg_addr), 16'(ptr_m));
            chk("R9 reg_we", 16'(reg_we), 16'(!r && ptr_m <= 5'h19));
            chk("R9 reg_re", 16'(reg_re), 16'(r && ptr_m <= 5'h19));
            if (r) begin
                is_rd = 1'b1;
                if (ptr_m <= 5'h19)      exp = ext_val(ptr_m);
                else if (ptr_m == 5'h1A) exp = {7'b0, idx_m[8]};
                else if (ptr_m == 5'h1B) exp = idx_m[7:0];
                else if (ptr_m == 5'h1D) begin exp = ram_m[idx_m]; idx_m = idx_m + 9'd1; end
                else                     exp = 8'h00;
            end else begin
                if (ptr_m == 5'h1A)      idx_m[8] = d[0];
                else if (ptr_m == 5'h1B) idx_m[7:0] = d;
                else if (ptr_m == 5'h1C) begin ram_m[idx_m] = d; idx_m = idx_m + 9'd1; end
            end
            ptr_m = ptr_next(ptr_m);
        end else begin
            chk("R13 R2 no strobe outside data phase", 16'({reg_we, reg_re}), 16'h0);
            if (phase_m == 1) begin ptr_m = d[4:0]; phase_m = 2; end
        end
        @(posedge clk); #1;
        byte_valid = 1'b0;
        chk("R10 R2 R13 rdata_valid", 16'(rdata_valid), 16'(is_rd));
        if (is_rd) chk("R5 R6 R7 R8 rdata", 16'(rdata), 16'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1 freeze", 16'(freeze), 16'h0);
        chk("R1 tick_out", 16'(tick_out), 16'h0);
        chk("R1 rdata_valid", 16'(rdata_valid), 16'h0);
        chk("R1 rdata", 16'(rdata), 16'h0);

        // R1 R5: index reads as zero; address byte sent with rw=1 (R2)
        begin_txn(); byte_op(1'b1, 8'h1A); byte_op(1'b1, 8'h00); byte_op(1'b1, 8'h00); finish_txn();

        // R3: write index halves, pointer wraps 1Bh -> 00h
        begin_txn(); byte_op(1'b0, 8'h1A); byte_op(1'b0, 8'h00); byte_op(1'b0, 8'h00);
        byte_op(1'b1, 8'h00); finish_txn();

        // R6 R4: stream 512 bytes, index wraps back to 0
        begin_txn(); byte_op(1'b0, 8'h1C);
        for (int i = 0; i < 512; i++) byte_op(1'b0, 8'($urandom));
        finish_txn();
        begin_txn(); byte_op(1'b0, 8'h1B); byte_op(1'b1, 8'h00); finish_txn();

        // R7: read stream across the 511 -> 0 wrap
        begin_txn(); byte_op(1'b0, 8'h1A); byte_op(1'b0, 8'hFF); byte_op(1'b0, 8'hFE); finish_txn();
        begin_txn(); byte_op(1'b0, 8'h1D);
        for (int i = 0; i < 4; i++) byte_op(1'b1, 8'h00);
        finish_txn();

        // R8: write to 1Dh, read of 1Ch, accesses to 1Eh/1Fh
        begin_txn(); byte_op(1'b0, 8'h1D); byte_op(1'b0, 8'h77); finish_txn();
        begin_txn(); byte_op(1'b0, 8'h1C); byte_op(1'b1, 8'h00); finish_txn();
        begin_txn(); byte_op(1'b0, 8'h1E); byte_op(1'b1, 8'h00); byte_op(1'b1, 8'h00); finish_txn();
        begin_txn(); byte_op(1'b0, 8'h1F); byte_op(1'b0, 8'h33); byte_op(1'b0, 8'h44); finish_txn();
        begin_txn(); byte_op(1'b0, 8'h1A); byte_op(1'b1, 8'h00); byte_op(1'b1, 8'h00); finish_txn();
        begin_txn(); byte_op(1'b0, 8'h1D); byte_op(1'b1, 8'h00); finish_txn();

        // R13: bytes while idle change nothing
        byte_op(1'b0, 8'h1C); byte_op(1'b1, 8'h1D);
        begin_txn(); byte_op(1'b0, 8'h1A); byte_op(1'b1, 8'h00); byte_op(1'b1, 8'h00); finish_txn();

        // R12: unfrozen tick passes after one cycle
        tick_in = 1'b1; @(posedge clk); #1; tick_in = 1'b0;
        chk("R12 live tick", 16'(tick_out), 16'h1);
        @(posedge clk); #1;
        chk("R12 live tick ends", 16'(tick_out), 16'h0);

        // R12: ticks during freeze merge into one delayed tick
        begin_txn();
        for (int i = 0; i < 2; i++) begin
            tick_in = 1'b1; @(posedge clk); #1; tick_in = 1'b0;
            chk("R12 held while frozen", 16'(tick_out), 16'h0);
            @(posedge clk); #1;
        end
        finish_txn();
        chk("R12 not yet released", 16'(tick_out), 16'h0);
        @(posedge clk); #1;
        chk("R12 held tick released", 16'(tick_out), 16'h1);
        @(posedge clk); #1;
        chk("R12 single held tick", 16'(tick_out), 16'h0);

        // Random transactions
        for (int t = 0; t < 250; t++) begin
            int nb;
            begin_txn();
            byte_op(1'($urandom), 8'($urandom_range(0, 31)));
            nb = $urandom_range(1, 6);
            for (int k = 0; k < nb; k++) byte_op(1'($urandom), 8'($urandom));
            finish_txn();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule